// File: doc/BRIEF.md
# Single-Step Multiply/Divide Unit

This unit performs exactly one iteration of an unsigned multiply (W×W bits) or an unsigned divide (2W÷W bits) each time it is strobed. It has no sequencer of its own. The two halves of the working value, `hi` and `lo`, and the second operand come in from architecturally visible register fields. The updated halves go back out, and software writes them into those same fields. A complete multiply or divide is W successive strobes (eight at the default width). Nothing is held inside the unit between strobes, so an interrupt can be serviced between any two steps and the computation resumes where it left off.

Software loads the operands before the first step. For a multiply, `hi` is cleared, `lo` holds the multiplier and the operand input holds the multiplicand. After the last step, `{hi,lo}` holds the full 2W-bit product. For a divide, `{hi,lo}` holds the dividend, with `hi` smaller than the divisor, and the operand input holds the divisor. After the last step, `lo` holds the quotient and `hi` holds the remainder. Both operations are unsigned.

The results and flags are registered. They appear one cycle after the strobe and stay there until the next strobe.

Top module: `mds_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low), `hi_o`, `lo_o`, all four flags and `done_o` are 0.
- R2: `done_o` is 1 in exactly the cycle after a cycle with `step_i` high. When no strobe occurs, `hi_o`, `lo_o` and the flags keep their values whatever the data inputs do.
- R3: A multiply step (`div_sel_i`=0) works as follows.
  - If `lo_i[0]` is 1, it forms the (W+1)-bit sum `hi_i + opnd_i` and shifts {sum, `lo_i`} right by one place. `hi_o` gets the carry in its MSB.
  - Otherwise it shifts {0, `hi_i`, `lo_i`} right by one place.
  - `carry_o` is the carry-out of the add, and 0 when no add happens.
  - The bits of `lo_i` above bit 0 move down one place in `lo_o`.
- R4: Start from `hi`=0, `lo`=b and operand a, and feed each output pair back in as the next input. After W multiply steps, `{hi_o,lo_o}` equals a×b.
- R5: A divide step (`div_sel_i`=1) with a non-zero divisor works as follows.
  - It forms the (W+1)-bit value {`hi_i`, `lo_i[W-1]`}.
  - If that value is greater than or equal to `opnd_i`, it subtracts `opnd_i`, and the quotient bit is 1. Otherwise the quotient bit is 0.
  - `hi_o` receives the low W bits of the result.
  - `lo_o` = {`lo_i[W-2:0]`, quotient bit}.
  - `carry_o` equals the quotient bit.
- R6: Start from a dividend N with `hi` < d, and feed each output pair back in as the next input. After W divide steps, `lo_o` = N / d and `hi_o` = N mod d.
- R7: A divide step with `opnd_i`=0 sets `ovf_o`=1 and `carry_o`=0, and copies `hi_i` and `lo_i` unchanged to the outputs. Every other step clears `ovf_o`.
- R8: After every step, `zero_o` is 1 exactly when `{hi_o,lo_o}` is all zeros, and `neg_o` equals `hi_o[W-1]`.
- R9: The outputs of a step depend only on that step's inputs. Interleaving steps of other computations between the steps of a multiply or divide leaves its final result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Strobe: perform one step this cycle |
| div_sel_i | input | 1 | 0 = multiply step, 1 = divide step |
| hi_i | input | W | Upper half of working value |
| lo_i | input | W | Lower half of working value (multiplier / dividend low / quotient) |
| opnd_i | input | W | Multiplicand or divisor |
| hi_o | output | W | Updated upper half |
| lo_o | output | W | Updated lower half |
| carry_o | output | 1 | Add carry-out (multiply) or quotient bit (divide) |
| ovf_o | output | 1 | Divide by zero flag |
| zero_o | output | 1 | Updated 2W-bit value is zero |
| neg_o | output | 1 | MSB of updated upper half |
| done_o | output | 1 | Results updated in this cycle |

## Verification
The hardest situation to reach from the ports is a computation whose steps are split by unrelated work, as when an interrupt handler runs a step of its own between two steps of a computation. The bench keeps two multiplies and a divide in flight at once in its own variables and rotates single steps among them. It checks that each one still reaches its arithmetic result. The 8-bit configuration is swept on a stride grid of operands for single steps, for complete products and for quotient/remainder pairs. A run of zero-divisor steps checks that the register values come back untouched.

// File: rtl/mds_pkg.sv
package mds_pkg;

  typedef enum logic {
    MDS_OP_MUL = 1'b0,
    MDS_OP_DIV = 1'b1
  } mds_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } mds_flags_t;

endpackage

// File: rtl/mds_mul_step.sv
module mds_mul_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] hi_nx,
  output logic [W-1:0] lo_nx,
  output logic         cout,
  output logic         add_fire
);
  localparam int SW = W + 1;

  // Sum of upper half and multiplicand, kept one bit wide for the carry.
  function automatic logic [SW-1:0] add_part(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic         en);
    add_part = en ? ({1'b0, a} + {1'b0, b}) : {1'b0, a};
  endfunction

  logic [SW-1:0] part;

  always_comb begin
    add_fire = lo[0];
    part     = add_part(hi, mcand, add_fire);
    hi_nx    = part[SW-1:1];
    lo_nx    = {part[0], lo[W-1:1]};
    cout     = part[SW-1];
  end

endmodule

// File: rtl/mds_div_step.sv
module mds_div_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] dvsr,
  output logic [W-1:0] hi_nx,
  output logic [W-1:0] lo_nx,
  output logic         qbit,
  output logic         dz
);
  localparam int RW = W + 1;

  // Shifted partial remainder: upper half with the next dividend bit appended.
  function automatic logic [RW-1:0] trial_rem(input logic [W-1:0] h,
                                              input logic         nb);
    trial_rem = {h, nb};
  endfunction

  logic [RW-1:0] rem;
  logic [RW-1:0] diff;

  always_comb begin
    dz    = (dvsr == '0);
    rem   = trial_rem(hi, lo[W-1]);
    diff  = rem - {1'b0, dvsr};
    qbit  = !dz && (rem >= {1'b0, dvsr});
    if (dz) begin
      hi_nx = hi;
      lo_nx = lo;
    end else begin
      hi_nx = qbit ? diff[W-1:0] : rem[W-1:0];
      lo_nx = {lo[W-2:0], qbit};
    end
  end

endmodule

// File: rtl/mds_result_sel.sv
module mds_result_sel
  import mds_pkg::*;
#(
  parameter int W = 8
) (
  input  mds_op_e      op,
  input  logic [W-1:0] mul_hi,
  input  logic [W-1:0] mul_lo,
  input  logic         mul_c,
  input  logic [W-1:0] div_hi,
  input  logic [W-1:0] div_lo,
  input  logic         div_q,
  input  logic         div_z,
  output logic [W-1:0] hi_sel,
  output logic [W-1:0] lo_sel,
  output mds_flags_t   flags
);
  always_comb begin
    if (op == MDS_OP_DIV) begin
      hi_sel  = div_hi;
      lo_sel  = div_lo;
      flags.c = div_q;
      flags.v = div_z;
    end else begin
      hi_sel  = mul_hi;
      lo_sel  = mul_lo;
      flags.c = mul_c;
      flags.v = 1'b0;
    end
    flags.z = ({hi_sel, lo_sel} == '0);
    flags.n = hi_sel[W-1];
  end

endmodule

// File: rtl/mds_unit.sv
module mds_unit
  import mds_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         div_sel_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         done_o
);
  // Named internal events, brought out for the checker.
  logic         mul_add_fire;
  logic         div_zero;
  logic         div_qbit;

  logic [W-1:0] mul_hi, mul_lo, div_hi, div_lo, hi_sel, lo_sel;
  logic         mul_c;
  mds_flags_t   flags_nx, flags_q;
  mds_op_e      op;

  assign op = mds_op_e'(div_sel_i);

  mds_mul_step #(.W(W)) u_mul (
    .hi(hi_i), .lo(lo_i), .mcand(opnd_i),
    .hi_nx(mul_hi), .lo_nx(mul_lo), .cout(mul_c), .add_fire(mul_add_fire)
  );

  mds_div_step #(.W(W)) u_div (
    .hi(hi_i), .lo(lo_i), .dvsr(opnd_i),
    .hi_nx(div_hi), .lo_nx(div_lo), .qbit(div_qbit), .dz(div_zero)
  );

  mds_result_sel #(.W(W)) u_sel (
    .op(op),
    .mul_hi(mul_hi), .mul_lo(mul_lo), .mul_c(mul_c),
    .div_hi(div_hi), .div_lo(div_lo), .div_q(div_qbit), .div_z(div_zero),
    .hi_sel(hi_sel), .lo_sel(lo_sel), .flags(flags_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_o    <= '0;
      lo_o    <= '0;
      flags_q <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= step_i;
      if (step_i) begin
        hi_o    <= hi_sel;
        lo_o    <= lo_sel;
        flags_q <= flags_nx;
      end
    end
  end

  assign carry_o = flags_q.c;
  assign ovf_o   = flags_q.v;
  assign zero_o  = flags_q.z;
  assign neg_o   = flags_q.n;

endmodule

// File: rtl/mds_unit_chk.sv
module mds_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_i,
  input logic         div_sel_i,
  input logic [W-1:0] hi_i,
  input logic [W-1:0] lo_i,
  input logic [W-1:0] opnd_i,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic         done_o,
  input logic         mul_add_fire,
  input logic         div_zero
);
  // R2
  done_follows_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> done_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> (!done_o && $stable(hi_o) && $stable(lo_o) && $stable(carry_o)
                 && $stable(ovf_o)));

  // R3
  mul_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !div_sel_i) |=> (lo_o[W-2:0] == $past(lo_i[W-1:1])));

  // R3
  mul_noadd_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !div_sel_i && !mul_add_fire) |=> (!carry_o && !neg_o));

  // R5
  div_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && div_sel_i && !div_zero) |=>
      (lo_o[W-1:1] == $past(lo_i[W-2:0]) && lo_o[0] == carry_o));

  // R7
  div_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && div_sel_i && opnd_i == '0) |=>
      (ovf_o && !carry_o && hi_o == $past(hi_i) && lo_o == $past(lo_i)));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !(div_sel_i && opnd_i == '0)) |=> !ovf_o);

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (zero_o == (hi_o == '0 && lo_o == '0)) && (neg_o == hi_o[W-1]));

endmodule

bind mds_unit mds_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_i(step_i), .div_sel_i(div_sel_i),
  .hi_i(hi_i), .lo_i(lo_i), .opnd_i(opnd_i),
  .hi_o(hi_o), .lo_o(lo_o), .carry_o(carry_o), .ovf_o(ovf_o),
  .zero_o(zero_o), .neg_o(neg_o), .done_o(done_o),
  .mul_add_fire(mul_add_fire), .div_zero(div_zero)
);

// File: tb/mds_unit_bench.sv
`timescale 1ns/1ps
module mds_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_i = 1'b0;
  logic       div_sel_i = 1'b0;
  logic [7:0] hi_i = '0, lo_i = '0, opnd_i = '0;
  logic [7:0] hi_o, lo_o;
  logic       carry_o, ovf_o, zero_o, neg_o, done_o;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mds_unit #(.W(8)) u_mds_unit (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .div_sel_i(div_sel_i),
    .hi_i(hi_i), .lo_i(lo_i), .opnd_i(opnd_i),
    .hi_o(hi_o), .lo_o(lo_o), .carry_o(carry_o), .ovf_o(ovf_o),
    .zero_o(zero_o), .neg_o(neg_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    vec_cnt++;
    if (act != exp) begin
      err_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Arithmetic model of one multiply step: returns {carry, hi, lo}.
  function automatic int model_mul(input int h, input int l, input int a);
    int acc;
    int c;
    acc = h;
    c = 0;
    if (l % 2 == 1) begin
      acc = h + a;
      c = (acc > 255) ? 1 : 0;
    end
    return (c << 16) | ((acc * 256 + l) / 2);
  endfunction

  // Arithmetic model of one divide step: returns {v, q, hi, lo}.
  function automatic int model_div(input int h, input int l, input int d);
    int r;
    int q;
    if (d == 0) return (1 << 17) | (h * 256 + l);
    r = h * 2 + l / 128;
    q = (r >= d) ? 1 : 0;
    if (q == 1) r = r - d;
    return (q << 16) | ((r % 256) * 256) | ((l * 2) % 256) | q;
  endfunction

  // Drives one step at a falling edge and samples at the next falling edge.
  task automatic do_step(input bit dv, input int h, input int l, input int d,
                         output int rh, output int rl);
    step_i    = 1'b1;
    div_sel_i = dv;
    hi_i      = 8'(h);
    lo_i      = 8'(l);
    opnd_i    = 8'(d);
    @(negedge clk);
    step_i = 1'b0;
    rh = int'(hi_o);
    rl = int'(lo_o);
  endtask

  // Single step with full comparison against the model.
  task automatic step_check(input bit dv, input int h, input int l, input int d,
                            output int rh, output int rl);
    int m;
    int eh, el, ec, ev;
    do_step(dv, h, l, d, rh, rl);
    m  = dv ? model_div(h, l, d) : model_mul(h, l, d);
    eh = (m >> 8) & 255;
    el = m & 255;
    ec = (m >> 16) & 1;
    ev = (m >> 17) & 1;
    if (dv) begin
      check(ev == 1 ? "R7 hi" : "R5 hi", rh, eh);
      check(ev == 1 ? "R7 lo" : "R5 lo", rl, el);
      check("R5 carry", int'(carry_o), ec);
    end else begin
      check("R3 hi", rh, eh);
      check("R3 lo", rl, el);
      check("R3 carry", int'(carry_o), ec);
    end
    check("R7 ovf", int'(ovf_o), ev);
    check("R8 zero", int'(zero_o), (eh == 0 && el == 0) ? 1 : 0);
    check("R8 neg", int'(neg_o), eh / 128);
    check("R2 done", int'(done_o), 1);
  endtask

  initial begin : main
    int rh, rl, h, l;
    int ah, al, bh, bl, ch, cl;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 hi", int'(hi_o), 0);
    check("R1 lo", int'(lo_o), 0);
    check("R1 flags", int'({carry_o, ovf_o, zero_o, neg_o}), 0);
    check("R1 done", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 single multiply steps over a stride grid
    for (int hv = 0; hv < 256; hv += 37)
      for (int lv = 0; lv < 256; lv += 11)
        for (int dv = 0; dv < 256; dv += 23)
          step_check(1'b0, hv, lv, dv, rh, rl);

    // R5 single divide steps (hi below divisor)
    for (int dv = 1; dv < 256; dv += 19)
      for (int hv = 0; hv < dv; hv += 13)
        for (int lv = 0; lv < 256; lv += 29)
          step_check(1'b1, hv, lv, dv, rh, rl);

    // R7 zero divisor leaves values untouched
    for (int hv = 0; hv < 256; hv += 31)
      for (int lv = 0; lv < 256; lv += 41)
        step_check(1'b1, hv, lv, 0, rh, rl);

    // R2 hold: inputs change without strobe
    step_check(1'b0, 8'h35, 8'h9B, 8'hC7, rh, rl);
    h = rh; l = rl;
    hi_i = 8'hFF; lo_i = 8'h01; opnd_i = 8'h00; div_sel_i = 1'b1;
    @(negedge clk);
    check("R2 done low", int'(done_o), 0);
    @(negedge clk);
    check("R2 hold hi", int'(hi_o), h);
    check("R2 hold lo", int'(lo_o), l);
    check("R2 hold ovf", int'(ovf_o), 0);

    // R4 full products
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 7) begin
        h = 0; l = b;
        for (int k = 0; k < 8; k++) begin
          do_step(1'b0, h, l, a, rh, rl);
          h = rh; l = rl;
        end
        check("R4 product", h * 256 + l, a * b);
      end

    // R6 full quotient and remainder
    for (int d = 1; d < 256; d += 6)
      for (int n = 0; n < 40; n++) begin
        int dividend;
        dividend = (n * 1657 + d * 31) % (d * 256);
        h = dividend / 256; l = dividend % 256;
        for (int k = 0; k < 8; k++) begin
          do_step(1'b1, h, l, d, rh, rl);
          h = rh; l = rl;
        end
        check("R6 quotient", l, dividend / d);
        check("R6 remainder", h, dividend % d);
      end

    // R9 interleaved computations, rotating single steps
    for (int t = 1; t < 60; t++) begin
      int ma, mb, na, nb, dd, dn;
      ma = (t * 53) % 256; mb = (t * 97 + 3) % 256;
      na = (t * 29 + 11) % 256; nb = (t * 71) % 256;
      dd = (t * 13) % 255 + 1; dn = (t * 4099) % (dd * 256);
      ah = 0; al = mb; bh = 0; bl = nb; ch = dn / 256; cl = dn % 256;
      for (int k = 0; k < 8; k++) begin
        do_step(1'b0, ah, al, ma, ah, al);
        do_step(1'b1, ch, cl, dd, ch, cl);
        do_step(1'b0, bh, bl, na, bh, bl);
      end
      check("R9 product A", ah * 256 + al, ma * mb);
      check("R9 product B", bh * 256 + bl, na * nb);
      check("R9 divide", ch * 256 + cl, (dn % dd) * 256 + dn / dd);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      err_cnt++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

endmodule